// File: doc/BRIEF.md
# Stack and Read-Modify-Write Bus Sequencer

This block produces the exact cycle-by-cycle bus traffic that an 8-bit processor generates for its stack operations and for memory read-modify-write operations. A command is presented together with the current stack pointer, the program counter, an address and a data byte. The block then drives one bus cycle per clock. Each cycle carries an address, a write enable, write data and a tag that marks the cycle as a dummy access. When the sequence completes, the block reports the updated stack pointer, program counter and data byte.

The stack sits in one fixed page at 0x0100. A push writes at the current pointer and then decrements it. A pull first increments the pointer and then reads. 16-bit values go onto the stack high byte first, so the low byte sits at the lower address. The arithmetic of a modify operation is done outside the block. The byte that was read is offered on `rmw_old`, and the new byte comes back on `mod_result` during the final write cycle.

Instruction decode and interrupt entry belong to the surrounding core. This block only sequences the bus and adjusts the pointer and program counter.

Top module: `stk_rmw_sequencer`

## Requirements
- R1: After reset, and whenever no command is running, `busy`, `bus_valid`, `bus_we`, `bus_dummy` and `done` are all 0.
- R2: A command is taken at a clock edge only while `busy` is 0. `busy` and `bus_valid` are high from the cycle after acceptance through the last bus cycle. `done` pulses for exactly one cycle right after that last cycle. A `cmd_valid` seen while busy has no effect on the running sequence or on its results.
- R3: Push byte (`cmd_op`=0) is one write of `cmd_data` to {0x01, SP}, not tagged dummy. The result SP is SP−1, wrapping within 8 bits. The result PC is the command PC, and the result data is `cmd_data`.
- R4: Push status (`cmd_op`=1) behaves like R3, except that the stored byte and the result data are `cmd_data` with bits 5 and 4 set.
- R5: Pull byte (`cmd_op`=2) is a dummy read at PC, followed by a read at {0x01, SP+1}. The result SP is SP+1 and the result data is the byte that was read.
- R6: Pull status (`cmd_op`=3) behaves like R5, except that the result data is the byte read ANDed with 0xCF, which clears bits 5 and 4.
- R7: Subroutine call (`cmd_op`=4) runs three cycles in order. First, a dummy read at PC. Second, a write of the high byte of PC−1 to {0x01, SP}. Third, a write of the low byte of PC−1 to {0x01, SP−1}. The result SP is SP−2 and the result PC is `cmd_addr`.
- R8: Subroutine return (`cmd_op`=5) runs four cycles in order: a read of the low byte at {0x01, SP+1}, a read of the high byte at {0x01, SP+2}, then two dummy reads at PC. The result SP is SP+2 and the result PC is {high, low}+1.
- R9: Return from interrupt (`cmd_op`=6) starts with a dummy read at PC. It then reads the status at {0x01, SP+1}, the PC low byte at SP+2 and the PC high byte at SP+3, all in page 0x01. The result data is the status ANDed with 0xCF, the result PC is {high, low} with no increment, and the result SP is SP+3.
- R10: Modify (`cmd_op`=7) runs three cycles at `cmd_addr`: a read, a dummy write of the unchanged byte, then a write of `mod_result`. `rmw_old` holds the byte that was read. The result data is `mod_result`, and SP and PC are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code (0..7, see requirements) |
| cmd_sp | input | 8 | Stack pointer at command start |
| cmd_pc | input | 16 | Program counter at command start |
| cmd_addr | input | 16 | Call target or modify address |
| cmd_data | input | 8 | Byte or status to push |
| mod_result | input | 8 | Modified byte, sampled in the final modify write cycle |
| bus_rdata | input | 8 | Read data for the current bus cycle |
| busy | output | 1 | Sequence in progress |
| bus_valid | output | 1 | A bus cycle is driven this clock |
| bus_addr | output | 16 | Bus address |
| bus_we | output | 1 | Write enable |
| bus_wdata | output | 8 | Write data |
| bus_dummy | output | 1 | Current cycle is a dummy access |
| rmw_old | output | 8 | Byte read by the last modify command |
| done | output | 1 | One-cycle completion pulse |
| res_sp | output | 8 | Updated stack pointer |
| res_pc | output | 16 | Updated program counter |
| res_data | output | 8 | Result byte (pushed, pulled, status or modified) |

## Verification
A command is taken at clock edge E. Its first bus cycle appears in the clock that follows E, and bus cycle k occupies the k-th clock after E. `done` and the result registers are valid in clock N+1, where N is the command's cycle count. The bench drives a command at a falling edge and then samples every following falling edge. At each of those edges it compares the bus against the expected cycle for that position, and it reads the results exactly at clock N+1. Read data comes from an address-derived function, so every pulled byte and resulting PC can be computed arithmetically.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH_BYTE = 3'd0,
    OP_PUSH_STAT = 3'd1,
    OP_PULL_BYTE = 3'd2,
    OP_PULL_STAT = 3'd3,
    OP_CALL      = 3'd4,
    OP_RETURN    = 3'd5,
    OP_RTI       = 3'd6,
    OP_RMW       = 3'd7
  } stk_op_e;

  localparam int STEP_W = 2;

  // status bits forced high on push, cleared on pull
  localparam logic [7:0] STAT_FORCE = 8'h30;
  localparam logic [7:0] STAT_KEEP  = 8'hCF;

  // index of the final bus cycle for each command
  function automatic logic [STEP_W-1:0] op_last_step(stk_op_e op);
    case (op)
      OP_PUSH_BYTE, OP_PUSH_STAT: op_last_step = 2'd0;
      OP_PULL_BYTE, OP_PULL_STAT: op_last_step = 2'd1;
      OP_CALL, OP_RMW:            op_last_step = 2'd2;
      default:                    op_last_step = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              cmd_valid,
  input  stk_op_e           cmd_op,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output stk_op_e           op_q,
  output logic              accept,
  output logic              last,
  output logic              done
);

  logic              active_d, done_d;
  logic [STEP_W-1:0] step_d;
  stk_op_e           op_d;

  assign accept = cmd_valid & ~active;
  assign last   = active & (step == op_last_step(op_q));

  always_comb begin
    active_d = active;
    step_d   = step;
    op_d     = op_q;
    done_d   = 1'b0;
    if (accept) begin
      active_d = 1'b1;
      step_d   = '0;
      op_d     = cmd_op;
    end else if (active) begin
      if (last) begin
        active_d = 1'b0;
        step_d   = '0;
        done_d   = 1'b1;
      end else begin
        step_d = step + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active <= 1'b0;
      step   <= '0;
      op_q   <= OP_PUSH_BYTE;
      done   <= 1'b0;
    end else begin
      active <= active_d;
      step   <= step_d;
      op_q   <= op_d;
      done   <= done_d;
    end
  end

  p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    active |-> (step <= op_last_step(op_q)));

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> !active);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> $past(active));

  p_busy_holds_op_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    active |=> $stable(op_q));

endmodule

// File: rtl/stk_bus_decode.sv
module stk_bus_decode
  import stk_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int          DW   = 8,
  parameter logic [AW-DW-1:0] PAGE = 'h01
)(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              active,
  input  stk_op_e           op,
  input  logic [STEP_W-1:0] step,
  input  logic [DW-1:0]     sp,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     tgt,
  input  logic [DW-1:0]     data,
  input  logic [DW-1:0]     lo_b,
  input  logic [DW-1:0]     hi_b,
  input  logic [DW-1:0]     stat_b,
  input  logic [DW-1:0]     old_b,
  input  logic [DW-1:0]     mod_result,
  input  logic [DW-1:0]     rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_we,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_dummy,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic              cap_stat,
  output logic              cap_old,
  output logic [AW-1:0]     fin_pc,
  output logic [DW-1:0]     fin_data
);

  localparam logic [DW-1:0] FORCE_M = DW'(STAT_FORCE);
  localparam logic [DW-1:0] KEEP_M  = DW'(STAT_KEEP);

  logic [AW-1:0] stk_now, stk_up, pc_m1;

  assign stk_now = {PAGE, sp};
  assign stk_up  = {PAGE, sp + DW'(1)};
  assign pc_m1   = pc - AW'(1);

  always_comb begin
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    bus_dummy = 1'b0;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    cap_lo    = 1'b0;
    cap_hi    = 1'b0;
    cap_stat  = 1'b0;
    cap_old   = 1'b0;
    if (active) begin
      case (op)
        OP_PUSH_BYTE, OP_PUSH_STAT: begin
          bus_addr  = stk_now;
          bus_we    = 1'b1;
          bus_wdata = (op == OP_PUSH_STAT) ? (data | FORCE_M) : data;
          sp_dec    = 1'b1;
        end
        OP_PULL_BYTE, OP_PULL_STAT: begin
          if (step == STEP_W'(0)) begin
            bus_addr  = pc;
            bus_dummy = 1'b1;
          end else begin
            bus_addr = stk_up;
            sp_inc   = 1'b1;
          end
        end
        OP_CALL: begin
          if (step == STEP_W'(0)) begin
            bus_addr  = pc;
            bus_dummy = 1'b1;
          end else begin
            bus_addr  = stk_now;
            bus_we    = 1'b1;
            bus_wdata = (step == STEP_W'(1)) ? pc_m1[AW-1 -: DW] : pc_m1[DW-1:0];
            sp_dec    = 1'b1;
          end
        end
        OP_RETURN: begin
          if (step < STEP_W'(2)) begin
            bus_addr = stk_up;
            sp_inc   = 1'b1;
            cap_lo   = (step == STEP_W'(0));
            cap_hi   = (step == STEP_W'(1));
          end else begin
            bus_addr  = pc;
            bus_dummy = 1'b1;
          end
        end
        OP_RTI: begin
          if (step == STEP_W'(0)) begin
            bus_addr  = pc;
            bus_dummy = 1'b1;
          end else begin
            bus_addr = stk_up;
            sp_inc   = 1'b1;
            cap_stat = (step == STEP_W'(1));
            cap_lo   = (step == STEP_W'(2));
          end
        end
        default: begin
          bus_addr = tgt;
          case (step)
            STEP_W'(0): cap_old = 1'b1;
            STEP_W'(1): begin
              bus_we    = 1'b1;
              bus_wdata = old_b;
              bus_dummy = 1'b1;
            end
            default: begin
              bus_we    = 1'b1;
              bus_wdata = mod_result;
            end
          endcase
        end
      endcase
    end
  end

  // values committed at the final bus cycle
  always_comb begin
    case (op)
      OP_CALL:   fin_pc = tgt;
      OP_RETURN: fin_pc = {hi_b, lo_b} + AW'(1);
      OP_RTI:    fin_pc = {rdata, lo_b};
      default:   fin_pc = pc;
    endcase
    case (op)
      OP_PUSH_BYTE: fin_data = data;
      OP_PUSH_STAT: fin_data = data | FORCE_M;
      OP_PULL_BYTE: fin_data = rdata;
      OP_PULL_STAT: fin_data = rdata & KEEP_M;
      OP_RTI:       fin_data = stat_b;
      OP_RMW:       fin_data = mod_result;
      default:      fin_data = data;
    endcase
  end

  p_rmw_order_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (active && op == OP_RMW && step == STEP_W'(2)) |->
      ($past(bus_we) && $past(bus_dummy) && $past(bus_addr) == bus_addr));

  p_write_real_data_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_we && !bus_dummy) |-> !sp_inc);

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath #(
  parameter int AW = 16,
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          accept,
  input  logic          last,
  input  logic [DW-1:0] cmd_sp,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] rdata,
  input  logic          sp_inc,
  input  logic          sp_dec,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          cap_stat,
  input  logic          cap_old,
  input  logic [AW-1:0] fin_pc,
  input  logic [DW-1:0] fin_data,
  output logic [DW-1:0] sp_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] tgt_q,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] old_q,
  output logic [DW-1:0] res_sp,
  output logic [AW-1:0] res_pc,
  output logic [DW-1:0] res_data
);

  localparam logic [DW-1:0] KEEP_M = DW'(stk_pkg::STAT_KEEP);

  logic [DW-1:0] sp_d;

  always_comb begin
    sp_d = sp_q;
    if (accept)      sp_d = cmd_sp;
    else if (sp_inc) sp_d = sp_q + DW'(1);
    else if (sp_dec) sp_d = sp_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sp_q   <= '0;
      pc_q   <= '0;
      tgt_q  <= '0;
      dat_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      stat_q <= '0;
      old_q  <= '0;
    end else begin
      sp_q <= sp_d;
      if (accept) begin
        pc_q  <= cmd_pc;
        tgt_q <= cmd_addr;
        dat_q <= cmd_data;
      end
      if (cap_lo)   lo_q   <= rdata;
      if (cap_hi)   hi_q   <= rdata;
      if (cap_stat) stat_q <= rdata & KEEP_M;
      if (cap_old)  old_q  <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      res_sp   <= '0;
      res_pc   <= '0;
      res_data <= '0;
    end else if (last) begin
      res_sp   <= sp_d;
      res_pc   <= fin_pc;
      res_data <= fin_data;
    end
  end

  p_sp_dec_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(sp_dec) |-> (sp_q == $past(sp_q) - DW'(1)));

  p_sp_inc_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(sp_inc) |-> (sp_q == $past(sp_q) + DW'(1)));

  p_stat_clean_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(cap_stat) |-> (stat_q[5:4] == 2'b00));

endmodule

// File: rtl/stk_rmw_sequencer.sv
module stk_rmw_sequencer
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_sp,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [DW-1:0] mod_result,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_dummy,
  output logic [DW-1:0] rmw_old,
  output logic          done,
  output logic [DW-1:0] res_sp,
  output logic [AW-1:0] res_pc,
  output logic [DW-1:0] res_data
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic              active, accept, last;
  logic [STEP_W-1:0] step;
  stk_op_e           op_q;
  logic              sp_inc, sp_dec, cap_lo, cap_hi, cap_stat, cap_old;
  logic [AW-1:0]     pc_q, tgt_q, fin_pc;
  logic [DW-1:0]     sp_q, dat_q, lo_q, hi_q, stat_q, fin_data;

  stk_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .cmd_valid (cmd_valid),
    .cmd_op    (stk_op_e'(cmd_op)),
    .active    (active),
    .step      (step),
    .op_q      (op_q),
    .accept    (accept),
    .last      (last),
    .done      (done)
  );

  stk_bus_decode #(.AW(AW), .DW(DW), .PAGE(STACK_PAGE)) u_dec (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .active     (active),
    .op         (op_q),
    .step       (step),
    .sp         (sp_q),
    .pc         (pc_q),
    .tgt        (tgt_q),
    .data       (dat_q),
    .lo_b       (lo_q),
    .hi_b       (hi_q),
    .stat_b     (stat_q),
    .old_b      (rmw_old),
    .mod_result (mod_result),
    .rdata      (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_dummy  (bus_dummy),
    .sp_inc     (sp_inc),
    .sp_dec     (sp_dec),
    .cap_lo     (cap_lo),
    .cap_hi     (cap_hi),
    .cap_stat   (cap_stat),
    .cap_old    (cap_old),
    .fin_pc     (fin_pc),
    .fin_data   (fin_data)
  );

  stk_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .accept   (accept),
    .last     (last),
    .cmd_sp   (cmd_sp),
    .cmd_pc   (cmd_pc),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .rdata    (bus_rdata),
    .sp_inc   (sp_inc),
    .sp_dec   (sp_dec),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .cap_stat (cap_stat),
    .cap_old  (cap_old),
    .fin_pc   (fin_pc),
    .fin_data (fin_data),
    .sp_q     (sp_q),
    .pc_q     (pc_q),
    .tgt_q    (tgt_q),
    .dat_q    (dat_q),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .stat_q   (stat_q),
    .old_q    (rmw_old),
    .res_sp   (res_sp),
    .res_pc   (res_pc),
    .res_data (res_data)
  );

  assign busy      = active;
  assign bus_valid = active;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> (!bus_we && !bus_dummy));

endmodule

// File: tb/sim_stk_rmw_sequencer.sv
module sim_stk_rmw_sequencer;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_sp = '0;
  logic [15:0] cmd_pc = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic [7:0]  mod_result = '0;
  logic [7:0]  bus_rdata;
  logic        busy, bus_valid, bus_we, bus_dummy, done;
  logic [15:0] bus_addr, res_pc;
  logic [7:0]  bus_wdata, rmw_old, res_sp, res_data;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_rd(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_rd(bus_addr);

  stk_rmw_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sp(cmd_sp), .cmd_pc(cmd_pc), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .mod_result(mod_result), .bus_rdata(bus_rdata), .busy(busy),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_dummy(bus_dummy), .rmw_old(rmw_old),
    .done(done), .res_sp(res_sp), .res_pc(res_pc), .res_data(res_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  logic [15:0] e_addr [4];
  logic        e_we   [4];
  logic [7:0]  e_wd   [4];
  logic        e_dum  [4];

  task automatic set_cyc(input int k, input logic [15:0] a, input logic we,
                         input logic [7:0] wd, input logic dm);
    e_addr[k] = a; e_we[k] = we; e_wd[k] = wd; e_dum[k] = dm;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] sp,
                         input logic [15:0] pc, input logic [15:0] ad,
                         input logic [7:0] dt, input logic [7:0] mr,
                         input logic hold);
    int n;
    logic [7:0]  x_sp, x_data, old_b;
    logic [15:0] x_pc, pm1;
    string r;
    r = req_of(op);
    pm1 = pc - 16'd1;
    x_pc = pc; x_data = dt; old_b = 8'h00;
    case (op)
      3'd0: begin n = 1; set_cyc(0, {8'h01, sp}, 1, dt, 0); x_sp = sp - 8'd1; end
      3'd1: begin n = 1; set_cyc(0, {8'h01, sp}, 1, dt | 8'h30, 0);
                  x_sp = sp - 8'd1; x_data = dt | 8'h30; end
      3'd2, 3'd3: begin
        n = 2; set_cyc(0, pc, 0, 0, 1); set_cyc(1, {8'h01, sp + 8'd1}, 0, 0, 0);
        x_sp = sp + 8'd1; x_data = mem_rd({8'h01, sp + 8'd1});
        if (op == 3'd3) x_data = x_data & 8'hCF;
      end
      3'd4: begin
        n = 3; set_cyc(0, pc, 0, 0, 1);
        set_cyc(1, {8'h01, sp}, 1, pm1[15:8], 0);
        set_cyc(2, {8'h01, sp - 8'd1}, 1, pm1[7:0], 0);
        x_sp = sp - 8'd2; x_pc = ad;
      end
      3'd5: begin
        n = 4; set_cyc(0, {8'h01, sp + 8'd1}, 0, 0, 0);
        set_cyc(1, {8'h01, sp + 8'd2}, 0, 0, 0);
        set_cyc(2, pc, 0, 0, 1); set_cyc(3, pc, 0, 0, 1);
        x_sp = sp + 8'd2;
        x_pc = {mem_rd({8'h01, sp + 8'd2}), mem_rd({8'h01, sp + 8'd1})} + 16'd1;
      end
      3'd6: begin
        n = 4; set_cyc(0, pc, 0, 0, 1);
        set_cyc(1, {8'h01, sp + 8'd1}, 0, 0, 0);
        set_cyc(2, {8'h01, sp + 8'd2}, 0, 0, 0);
        set_cyc(3, {8'h01, sp + 8'd3}, 0, 0, 0);
        x_sp = sp + 8'd3;
        x_pc = {mem_rd({8'h01, sp + 8'd3}), mem_rd({8'h01, sp + 8'd2})};
        x_data = mem_rd({8'h01, sp + 8'd1}) & 8'hCF;
      end
      default: begin
        n = 3; old_b = mem_rd(ad);
        set_cyc(0, ad, 0, 0, 0); set_cyc(1, ad, 1, old_b, 1); set_cyc(2, ad, 1, mr, 0);
        x_sp = sp; x_data = mr;
      end
    endcase
    // present command; taken at next rising edge
    cmd_valid = 1'b1; cmd_op = op; cmd_sp = sp; cmd_pc = pc;
    cmd_addr = ad; cmd_data = dt; mod_result = mr;
    @(negedge clk);
    chk("R2", "busy in first cycle", {31'b0, busy}, 32'd1);
    if (hold) begin
      // a second request while busy must be ignored (R2)
      cmd_op = op ^ 3'd5; cmd_sp = ~sp; cmd_pc = ~pc; cmd_addr = ~ad; cmd_data = ~dt;
    end else begin
      cmd_valid = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      chk(r, $sformatf("cycle %0d addr", k), {16'b0, bus_addr}, {16'b0, e_addr[k]});
      chk(r, $sformatf("cycle %0d we/dummy/valid", k),
          {29'b0, bus_valid, bus_we, bus_dummy}, {29'b0, 1'b1, e_we[k], e_dum[k]});
      if (e_we[k]) chk(r, $sformatf("cycle %0d wdata", k), {24'b0, bus_wdata}, {24'b0, e_wd[k]});
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    chk("R2", "done pulse", {30'b0, done, busy}, {30'b0, 2'b10});
    chk(r, "res_sp", {24'b0, res_sp}, {24'b0, x_sp});
    chk(r, "res_pc", {16'b0, res_pc}, {16'b0, x_pc});
    chk(r, "res_data", {24'b0, res_data}, {24'b0, x_data});
    if (op == 3'd7) chk("R10", "rmw_old", {24'b0, rmw_old}, {24'b0, old_b});
    @(negedge clk);
    chk("R2", "done single cycle", {31'b0, done}, 32'd0);
    chk("R1", "idle bus", {29'b0, bus_valid, bus_we, bus_dummy}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  sps [6];
    logic [15:0] pcs [5];
    sps = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    pcs = '{16'h0000, 16'h1234, 16'h12FF, 16'h8000, 16'hFF00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {28'b0, busy, bus_valid, bus_we, done},
        32'd0);
    chk("R1", "reset dummy", {31'b0, bus_dummy}, 32'd0);
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 6; s++)
        for (int p = 0; p < 5; p++)
          for (int h = 0; h < 2; h++)
            run_cmd(3'(o), sps[s], pcs[p],
                    (pcs[p] ^ 16'h5AC3) + {8'h00, sps[s]},
                    pcs[p][7:0] + sps[s] + 8'(h),
                    sps[s] ^ pcs[p][15:8] ^ 8'h3C, h[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule